// File: doc/BRIEF.md
# Dual-Mode Converter Configuration Port

This block is the configuration front end of a data converter. Four shared pins (select, clock, data-in and a bidirectional data line) reach it, together with a mode input. With the mode input low, the pins form a serial register interface. A host shifts 16-bit frames into a small bank of mode registers and can read those registers back over an open-drain data line. With the mode input high, the same pins become static straps. Each strap sets one converter control directly, and the data line turns into an input that the block never drives.

The block has four decoded outputs: single-lane output, reduced drive current, power down and output termination enable. In serial mode they come from the register bank. In strap mode they follow the synchronised pins. All pins are brought into the system clock domain through a two-flop synchroniser, and serial clock edges are detected there. The serial clock must therefore run well below the system clock.

Top module: `cfgp_top`

## Requirements
- R1: After reset, all four control outputs are 0, `sdo_drive_n` is 1 (line released) and `sdo_out` is 0.
- R2: With `mode_strap` high, `one_lane` follows `pin_cs`, `half_current` follows `pin_sck`, `power_down` follows `pin_sdi` and `term_en` follows `pin_sdo_in`. A pin change shows at the output after the second rising edge of `clk`, and not after the first.
- R3: With `mode_strap` high, the block never pulls the data line (`sdo_drive_n` stays 1), and serial frames have no effect on the register bank. The register values show again at the outputs once `mode_strap` returns low.
- R4: In serial mode, a frame is 16 bits, MSB first, each captured on a rising edge of `pin_sck` while `pin_cs` is low. Bit 15 is 1 for a read and 0 for a write, bits 14:8 are the register address and bits 7:0 are the data. A write takes effect after the 16th rising edge. Register 1 bit 0 drives `power_down`. Register 2 bit 0 drives `one_lane` and register 2 bit 1 drives `half_current`. Register 3 bit 0 drives `term_en`. Register 3 bits 3:1 hold a test field that is stored and read back only.
- R5: For a read frame, after rising edges 9 to 16 the data line carries the addressed register, MSB first, so the host can latch each bit on the following falling edge. A 0 bit is driven low (`sdo_drive_n`=0, `sdo_out`=0), and a 1 bit releases the line.
- R6: Addresses 4 to 127 hold no register. Writes to them change nothing, and reads from them return 0.
- R7: Raising `pin_cs` before the 16th rising edge aborts the frame and leaves every register unchanged.
- R8: Writing 1 to bit 7 of register 0 clears all registers, including that bit, one clock after the write takes effect.
- R9: The data line is released whenever `pin_cs` is high, during the 8 header bits, and throughout a write frame.
- R10: Rising clock edges beyond the 16th, in a frame where `pin_cs` stays low, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | 0 selects serial registers, 1 selects strap pins |
| pin_cs | input | 1 | Serial select (active low) or lane-count strap |
| pin_sck | input | 1 | Serial clock or drive-current strap |
| pin_sdi | input | 1 | Serial data-in or power-down strap |
| pin_sdo_in | input | 1 | Sensed level of the data line, used as the termination strap |
| sdo_drive_n | output | 1 | Active-low enable of the open-drain pull-down |
| sdo_out | output | 1 | Data value driven while enabled, always 0 |
| one_lane | output | 1 | 1 selects single-lane output, 0 selects two lanes |
| half_current | output | 1 | 1 selects the lower output current, 0 the higher |
| power_down | output | 1 | Converter power-down request |
| term_en | output | 1 | Internal output termination enable |

## Verification
A strap change is due after two `clk` edges. The bench checks the old value after the first edge and the new value after the second, and the checker compares outputs against the pins delayed by two cycles. A serial event reaches the register bank and the data line three `clk` edges after the pin edge: two synchroniser flops plus the edge-detect register. The bench holds each serial clock phase for six system cycles. It samples the data line at the end of every high phase and pushes each expectation only after the frame and select release have settled. The monitor compares at the falling edge of `clk` that follows the push.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int FRAME_W = 16;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int HDR_W   = FRAME_W - DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int NREG    = 4;

    // register map: index and bit of each decoded control
    localparam int SWRST_REG = 0;
    localparam int SWRST_BIT = 7;
    localparam int PWR_REG   = 1;
    localparam int PWR_BIT   = 0;
    localparam int LANE_REG  = 2;
    localparam int LANE_BIT  = 0;
    localparam int CUR_BIT   = 1;
    localparam int TERM_REG  = 3;
    localparam int TERM_BIT  = 0;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic one_lane;
        logic half_current;
        logic power_down;
        logic term_en;
    } ctl_t;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfgp_serial.sv
module cfgp_serial
    import cfgp_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              cs_s,
    input  logic                              sck_s,
    input  logic                              sdi_s,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o,
    output logic                              sdo_pull
);
    localparam int RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int BIT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic [CNT_W-1:0]                 cnt;
        logic [FRAME_W-1:0]               shift;
        logic                             rd_act;
        byte_t                            rd;
        logic                             sck_prev;
        logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
    } st_t;

    st_t                st_d, st_q;
    logic               rise;
    logic [FRAME_W-1:0] sh_next;
    logic [ADDR_W-1:0]  hdr_addr;
    logic [ADDR_W-1:0]  wr_addr;
    logic [CNT_W-1:0]   pos;

    always_comb begin
        st_d     = st_q;
        rise     = sck_s & ~st_q.sck_prev;
        sh_next  = {st_q.shift[FRAME_W-2:0], sdi_s};
        hdr_addr = sh_next[ADDR_W-1:0];
        wr_addr  = sh_next[FRAME_W-2 -: ADDR_W];
        st_d.sck_prev = sck_s;

        // self-clearing software reset: the bit lives for one cycle
        if (st_q.regs[SWRST_REG][SWRST_BIT]) begin
            st_d.regs = '0;
        end

        if (!en || cs_s) begin
            st_d.cnt    = '0;
            st_d.rd_act = 1'b0;
        end else if (rise && (st_q.cnt < CNT_W'(FRAME_W))) begin
            st_d.shift = sh_next;
            st_d.cnt   = st_q.cnt + 1'b1;
            // header complete: latch direction and snapshot read data
            if (st_q.cnt == CNT_W'(HDR_W - 1)) begin
                st_d.rd_act = sh_next[HDR_W-1];
                st_d.rd     = (hdr_addr < ADDR_W'(NUM_REGS))
                            ? st_q.regs[hdr_addr[RIDX_W-1:0]] : '0;
            end
            // last bit of a write frame commits the data
            if ((st_q.cnt == CNT_W'(FRAME_W - 1)) && !sh_next[FRAME_W-1]
                && (wr_addr < ADDR_W'(NUM_REGS))) begin
                st_d.regs[wr_addr[RIDX_W-1:0]] = sh_next[DATA_W-1:0];
            end
        end

        pos      = CNT_W'(FRAME_W) - st_q.cnt;
        sdo_pull = en && !cs_s && st_q.rd_act && (st_q.cnt > CNT_W'(HDR_W))
                   && !st_q.rd[pos[BIT_W-1:0]];
        regs_o   = st_q.regs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter int NUM_REGS    = NREG,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_strap,
    input  logic pin_cs,
    input  logic pin_sck,
    input  logic pin_sdi,
    input  logic pin_sdo_in,
    output logic sdo_drive_n,
    output logic sdo_out,
    output logic one_lane,
    output logic half_current,
    output logic power_down,
    output logic term_en
);
    localparam int PIN_W = 5;

    logic [PIN_W-1:0]                pins_s;
    logic                            mode_s, cs_s, sck_s, sdi_s, sdo_in_s;
    logic [NUM_REGS-1:0][DATA_W-1:0] cfg_regs;
    logic                            ser_pull;
    ctl_t                            ctl;

    // select idles high, everything else low
    cfgp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b01000)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mode_strap, pin_cs, pin_sck, pin_sdi, pin_sdo_in}),
        .q     (pins_s)
    );

    assign {mode_s, cs_s, sck_s, sdi_s, sdo_in_s} = pins_s;

    cfgp_serial #(
        .NUM_REGS (NUM_REGS)
    ) i_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~mode_s),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .regs_o   (cfg_regs),
        .sdo_pull (ser_pull)
    );

    always_comb begin
        if (mode_s) begin
            ctl.one_lane     = cs_s;
            ctl.half_current = sck_s;
            ctl.power_down   = sdi_s;
            ctl.term_en      = sdo_in_s;
        end else begin
            ctl.one_lane     = cfg_regs[LANE_REG][LANE_BIT];
            ctl.half_current = cfg_regs[LANE_REG][CUR_BIT];
            ctl.power_down   = cfg_regs[PWR_REG][PWR_BIT];
            ctl.term_en      = cfg_regs[TERM_REG][TERM_BIT];
        end
    end

    assign {one_lane, half_current, power_down, term_en} = ctl;
    assign sdo_drive_n = ~ser_pull;
    assign sdo_out     = 1'b0;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
    import cfgp_pkg::*;
#(
    parameter int NUM_REGS = NREG
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         mode_strap,
    input logic                         pin_cs,
    input logic                         pin_sck,
    input logic                         pin_sdi,
    input logic                         pin_sdo_in,
    input logic                         sdo_drive_n,
    input logic                         one_lane,
    input logic                         half_current,
    input logic                         power_down,
    input logic                         term_en,
    input logic                         cs_s,
    input logic [NUM_REGS*DATA_W-1:0]   regs
);
    localparam int SWRST_POS = SWRST_REG * DATA_W + SWRST_BIT;

    logic [1:0] age_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign armed = (age_q == 2'd3);

    p_strap_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_strap, 2)) |->
        ({one_lane, half_current, power_down, term_en} ==
         {$past(pin_cs, 2), $past(pin_sck, 2), $past(pin_sdi, 2), $past(pin_sdo_in, 2)}));

    p_strap_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mode_strap, 2)) |-> sdo_drive_n);

    p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(pin_cs, 2)) |-> sdo_drive_n);

    p_regs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !regs[SWRST_POS]) |=> $stable(regs));

    p_swreset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        regs[SWRST_POS] |=> (regs == '0));
endmodule

bind cfgp_top cfgp_checker #(.NUM_REGS(NUM_REGS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_strap   (mode_strap),
    .pin_cs       (pin_cs),
    .pin_sck      (pin_sck),
    .pin_sdi      (pin_sdi),
    .pin_sdo_in   (pin_sdo_in),
    .sdo_drive_n  (sdo_drive_n),
    .one_lane     (one_lane),
    .half_current (half_current),
    .power_down   (power_down),
    .term_en      (term_en),
    .cs_s         (cs_s),
    .regs         (cfg_regs)
);

// File: tb/test_cfgp_top.sv
module test_cfgp_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 6;
    localparam int WATCHDOG   = 100000;

    localparam int K_OUTS = 0;  // {one_lane, half_current, power_down, term_en}
    localparam int K_READ = 1;  // byte captured from the data line
    localparam int K_SDO  = 2;  // {sdo_drive_n, sdo_out}
    localparam int K_PULL = 3;  // line pulled at any sample of the last frame

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_strap = 1'b0;
    logic pin_cs = 1'b1;
    logic pin_sck = 1'b0;
    logic pin_sdi = 1'b0;
    logic pin_sdo_in = 1'b0;
    logic sdo_drive_n, sdo_out, one_lane, half_current, power_down, term_en;

    item_t      exp_q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    logic [7:0] rd_capt = '0;
    logic       pull_seen = 1'b0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgp_top i_cfgp_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap   (mode_strap),
        .pin_cs       (pin_cs),
        .pin_sck      (pin_sck),
        .pin_sdi      (pin_sdi),
        .pin_sdo_in   (pin_sdo_in),
        .sdo_drive_n  (sdo_drive_n),
        .sdo_out      (sdo_out),
        .one_lane     (one_lane),
        .half_current (half_current),
        .power_down   (power_down),
        .term_en      (term_en)
    );

    // monitor: pops expectations and compares against the design
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t      it;
            logic [7:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                K_OUTS:  act = {4'b0, one_lane, half_current, power_down, term_en};
                K_READ:  act = rd_capt;
                K_SDO:   act = {6'b0, sdo_drive_n, sdo_out};
                default: act = {7'b0, pull_seen};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind %0d: actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push one expectation just after a rising edge
    task automatic expect_item(input string req, input int kind, input logic [7:0] exp);
        item_t it;
        @(posedge clk);
        #1;
        it.req  = req;
        it.kind = kind;
        it.exp  = exp;
        exp_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic spi_frame(input logic [15:0] w, input int nbits);
        pull_seen = 1'b0;
        pin_cs = 1'b0;
        idle(HALF_BIT);
        for (int i = 0; i < nbits; i++) begin
            pin_sdi = (i < 16) ? w[15-i] : 1'b1;
            idle(HALF_BIT);
            pin_sck = 1'b1;
            idle(HALF_BIT);
            if (!sdo_drive_n) pull_seen = 1'b1;
            if (i >= 8 && i < 16) rd_capt[15-i] = sdo_drive_n ? 1'b1 : sdo_out;
            pin_sck = 1'b0;
        end
        idle(HALF_BIT);
        pin_cs = 1'b1;
        idle(HALF_BIT);
    endtask

    task automatic spi_write(input logic [6:0] a, input logic [7:0] d);
        spi_frame({1'b0, a, d}, 16);
    endtask

    task automatic spi_read(input logic [6:0] a);
        spi_frame({1'b1, a, 8'h00}, 16);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        expect_item("R1 outputs", K_OUTS, 8'h00);
        expect_item("R1 sdo", K_SDO, 8'h02);

        // R4: writes reach the decoded outputs
        spi_write(7'd2, 8'h03);
        expect_item("R4 lane/current", K_OUTS, 8'h0C);
        expect_item("R9 write frame released", K_PULL, 8'h00);
        spi_write(7'd1, 8'hA5);
        expect_item("R4 power down", K_OUTS, 8'h0E);
        spi_write(7'd3, 8'h0B);
        expect_item("R4 termination", K_OUTS, 8'h0F);
        expect_item("R9 sdo released after frame", K_SDO, 8'h02);

        // R5: readback of mixed patterns
        spi_read(7'd3);
        expect_item("R5 read reg3", K_READ, 8'h0B);
        spi_read(7'd1);
        expect_item("R5 read reg1", K_READ, 8'hA5);
        spi_read(7'd2);
        expect_item("R5 read reg2", K_READ, 8'h03);
        expect_item("R9 cs high released", K_SDO, 8'h02);

        // R6: unmapped addresses
        spi_write(7'd5, 8'hFF);
        expect_item("R6 write ignored", K_OUTS, 8'h0F);
        spi_read(7'd5);
        expect_item("R6 read zero", K_READ, 8'h00);
        spi_read(7'h40);
        expect_item("R6 read high address", K_READ, 8'h00);

        // R7: aborted write
        spi_frame({1'b0, 7'd2, 8'h00}, 12);
        expect_item("R7 abort keeps outputs", K_OUTS, 8'h0F);
        spi_read(7'd2);
        expect_item("R7 abort keeps reg2", K_READ, 8'h03);

        // R10: clocks beyond 16 ignored
        spi_frame({1'b0, 7'd3, 8'h00}, 18);
        expect_item("R10 extra clocks", K_OUTS, 8'h0E);
        spi_read(7'd3);
        expect_item("R10 reg3 value", K_READ, 8'h00);

        // R8: software reset
        spi_write(7'd0, 8'h80);
        expect_item("R8 outputs cleared", K_OUTS, 8'h00);
        spi_read(7'd1);
        expect_item("R8 reg1 cleared", K_READ, 8'h00);
        spi_read(7'd0);
        expect_item("R8 reg0 self clears", K_READ, 8'h00);

        // R3 setup: known register state before strap mode
        spi_write(7'd2, 8'h02);
        expect_item("R4 half current only", K_OUTS, 8'h04);

        // R2: strap mode mapping and two-edge latency
        mode_strap = 1'b1;
        pin_cs = 1'b1; pin_sck = 1'b0; pin_sdi = 1'b1; pin_sdo_in = 1'b0;
        idle(4);
        expect_item("R2 pattern 1010", K_OUTS, 8'h0A);
        @(negedge clk);
        pin_cs = 1'b0; pin_sck = 1'b1; pin_sdi = 1'b0; pin_sdo_in = 1'b1;
        expect_item("R2 old after one edge", K_OUTS, 8'h0A);
        expect_item("R2 new after two edges", K_OUTS, 8'h05);
        pin_cs = 1'b1; pin_sck = 1'b1; pin_sdi = 1'b1; pin_sdo_in = 1'b1;
        idle(4);
        expect_item("R2 pattern 1111", K_OUTS, 8'h0F);
        expect_item("R3 strap sdo released", K_SDO, 8'h02);

        // R3: serial frames in strap mode
        pin_sck = 1'b0; pin_sdi = 1'b0; pin_sdo_in = 1'b0;
        spi_write(7'd2, 8'h00);
        spi_read(7'd2);
        expect_item("R3 no pull in strap", K_PULL, 8'h00);
        mode_strap = 1'b0;
        idle(4);
        expect_item("R3 registers kept", K_OUTS, 8'h04);

        idle(2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule